// File: doc/BRIEF.md
# Address Decode Window Unit

This unit steers each 32-bit transaction address to a target. It holds five programmable decode windows. Each window has an enable bit, a 4-bit target code, a base, a size mask and a remap base, and every one of these is stored in 64 KB units. A lookup compares the upper address half against every enabled window. The unit returns whether a window claimed the address, which window it was, that window's target code, and the address with its window-relative offset moved onto the remap base.

Software programs the windows through a small write/read port. The port selects a window index and one of four registers. To reconfigure a window safely, software first clears its enable bit, then writes the base, remap and size registers, and finally writes control with the target and the enable bit. Lookups are pipelined by one register stage, and each lookup uses the register contents that were in place before the clock edge that captures it.

Top module: `addr_window_decoder`

## Requirements
- R1: There are five independent windows, each holding four registers. The port selects the register with `reg_sel`: 0 = control, 1 = base, 2 = size, 3 = remap. Every register reads back through `reg_rdata` as written. In the control register, bit 0 is the enable bit and bits [7:4] hold the target code; all other control bits read as zero.
- R2: A window whose enable bit is clear never produces a hit, whatever its base, size and remap registers contain.
- R3: The size field is a run of ones starting at the LSB. A window spans (size + 1) × 64 KB starting at its base. The last address inside the span hits, and the first address past the span misses.
- R4: A window matches when (addr[31:16] & ~size) == (base & ~size). Address bits [15:0] never take part in the match.
- R5: On a hit, result address bits [31:16] are (remap & ~size) | (addr[31:16] & size), and bits [15:0] pass through unchanged.
- R6: When several enabled windows hit, the window with the lowest index wins, and `res_win` reports that index.
- R7: When no window hits, `res_miss` is 1, `res_hit` is 0, `res_target` is 0xF, `res_win` is 0, and `res_addr` equals the lookup address.
- R8: On a hit, `res_target` is the winning window's 4-bit target code. Codes 0 to 15 pass through unaltered, including the defined codes: 0 DRAM, 1 internal registers, 2 PCIe, 3 PCIe over the chip link, 4 boot ROM, 5 external link, 7 secure-processor RAM, 8 interconnect registers.
- R9: `res_valid` is high exactly in the cycle after the one in which `lk_valid` was high.
- R10: A register write changes lookups from the next cycle onward. A lookup issued in the same cycle as the write still sees the old value.
- R11: After reset, every register reads zero, every window is disabled, `res_valid` is low, and any lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_win | input | 3 | Window index for register access |
| reg_sel | input | 2 | Register select: 0 control, 1 base, 2 size, 3 remap |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 32 | Lookup address |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | A window claimed the address |
| res_miss | output | 1 | No window claimed the address |
| res_target | output | 4 | Target code, 0xF on a miss |
| res_win | output | 3 | Index of the winning window |
| res_addr | output | 32 | Remapped or passed-through address |

## Verification
The bench probes both edges of each window span: the last address inside it and the first address past it. A design that decoded the size as a byte count, or that left the low address half in the compare, would give the wrong answer at one of these two addresses. A remap through a two-unit window shows whether the offset bits that fall inside the size mask survive the translation; a design that overwrote them would send both 64 KB halves to the same place. Overlapping windows, a disabled window, and a write issued in the same cycle as a lookup catch, in turn, a reversed priority, an enable that is ignored, and a write that reaches the compare one cycle early.

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int NUM_WIN = 5,
  parameter int ADDR_W  = 32,
  parameter int GRAN_W  = 16,
  parameter int TGT_W   = 4,
  localparam int FIELD_W = ADDR_W - GRAN_W,
  localparam int IDX_W   = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [IDX_W-1:0]   reg_win,
  input  logic [1:0]         reg_sel,
  input  logic [FIELD_W-1:0] reg_wdata,
  output logic [FIELD_W-1:0] reg_rdata,
  input  logic               lk_valid,
  input  logic [ADDR_W-1:0]  lk_addr,
  output logic               res_valid,
  output logic               res_hit,
  output logic               res_miss,
  output logic [TGT_W-1:0]   res_target,
  output logic [IDX_W-1:0]   res_win,
  output logic [ADDR_W-1:0]  res_addr
);

  logic [NUM_WIN-1:0]  win_en;
  logic [TGT_W-1:0]    win_tgt   [NUM_WIN];
  logic [FIELD_W-1:0]  win_base  [NUM_WIN];
  logic [FIELD_W-1:0]  win_size  [NUM_WIN];
  logic [FIELD_W-1:0]  win_remap [NUM_WIN];
  logic [NUM_WIN-1:0]  hit_vec;

  wire [FIELD_W-1:0] addr_hi = lk_addr[ADDR_W-1:GRAN_W];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        win_en[i]    <= 1'b0;
        win_tgt[i]   <= '0;
        win_base[i]  <= '0;
        win_size[i]  <= '0;
        win_remap[i] <= '0;
      end else if (reg_we && reg_win == IDX_W'(i)) begin
        case (reg_sel)
          2'd0: begin
            win_en[i]  <= reg_wdata[0];
            win_tgt[i] <= reg_wdata[4 +: TGT_W];
          end
          2'd1: win_base[i]  <= reg_wdata;
          2'd2: win_size[i]  <= reg_wdata;
          default: win_remap[i] <= reg_wdata;
        endcase
      end
    end

    assign hit_vec[i] = win_en[i] &&
      ((addr_hi & ~win_size[i]) == (win_base[i] & ~win_size[i]));
  end

  logic [IDX_W-1:0] sel_idx;
  always_comb begin
    sel_idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--)
      if (hit_vec[i]) sel_idx = IDX_W'(i);
  end

  wire any_hit = |hit_vec;
  wire [FIELD_W-1:0] sel_size = win_size[sel_idx];
  wire [FIELD_W-1:0] xl_hi = (win_remap[sel_idx] & ~sel_size) | (addr_hi & sel_size);

  always_comb begin
    reg_rdata = '0;
    if (reg_win < IDX_W'(NUM_WIN)) begin
      case (reg_sel)
        2'd0: begin
          reg_rdata[0] = win_en[reg_win];
          reg_rdata[4 +: TGT_W] = win_tgt[reg_win];
        end
        2'd1: reg_rdata = win_base[reg_win];
        2'd2: reg_rdata = win_size[reg_win];
        default: reg_rdata = win_remap[reg_win];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_miss   <= 1'b0;
      res_target <= '0;
      res_win    <= '0;
      res_addr   <= '0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_hit    <= any_hit;
        res_miss   <= !any_hit;
        res_target <= any_hit ? win_tgt[sel_idx] : '1;
        res_win    <= any_hit ? sel_idx : '0;
        res_addr   <= any_hit ? {xl_hi, lk_addr[GRAN_W-1:0]} : lk_addr;
      end
    end
  end

  // R9
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);
  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);
  // R7
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_hit != res_miss));
  // R7
  miss_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_miss) |-> (res_target == '1 && res_addr == $past(lk_addr)));
  // R5
  offset_keep_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_addr[GRAN_W-1:0] == $past(lk_addr[GRAN_W-1:0])));
  // R2
  disabled_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit) |-> (($past(win_en) & (NUM_WIN'(1) << res_win)) != '0));

endmodule

// File: tb/sim_addr_window_decoder.sv
module sim_addr_window_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_win = '0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        res_valid, res_hit, res_miss;
  logic [3:0]  res_target;
  logic [2:0]  res_win;
  logic [31:0] res_addr;

  int n_chk = 0;
  int n_fail = 0;

  addr_window_decoder u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // {addr, hit, target, win, result address}
  localparam logic [71:0] VEC [NVEC] = '{
    {32'h0000_1234, 1'b1, 4'h0, 3'd0, 32'h0000_1234},
    {32'h07FF_FFFF, 1'b1, 4'h0, 3'd0, 32'h07FF_FFFF},
    {32'h0800_0000, 1'b0, 4'hF, 3'd0, 32'h0800_0000},
    {32'hE012_3456, 1'b1, 4'h5, 3'd1, 32'h1012_3456},
    {32'hE7FF_FFFF, 1'b1, 4'h5, 3'd1, 32'h17FF_FFFF},
    {32'hE800_0010, 1'b1, 4'h2, 3'd2, 32'hE800_0010},
    {32'hF000_ABCD, 1'b1, 4'h7, 3'd3, 32'h1FFE_ABCD},
    {32'hF001_0004, 1'b1, 4'h7, 3'd3, 32'h1FFF_0004},
    {32'hF002_0000, 1'b0, 4'hF, 3'd0, 32'hF002_0000},
    {32'h8FFF_FFFF, 1'b1, 4'h3, 3'd4, 32'h8FFF_FFFF},
    {32'h9000_0000, 1'b0, 4'hF, 3'd0, 32'h9000_0000},
    {32'hFFFF_FFFF, 1'b0, 4'hF, 3'd0, 32'hFFFF_FFFF}
  };

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_win = w; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic setwin(input logic [2:0] w, input logic [3:0] t, input logic [15:0] b,
                        input logic [15:0] sz, input logic [15:0] rm);
    wr(w, 2'd0, 16'h0000);
    wr(w, 2'd1, b);
    wr(w, 2'd3, rm);
    wr(w, 2'd2, sz);
    wr(w, 2'd0, {8'h00, t, 4'h1});
  endtask

  task automatic look(input logic [31:0] a);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_res(input string req, input bit h, input logic [3:0] t,
                            input logic [2:0] w, input logic [31:0] ra);
    logic [40:0] act, exp;
    act = {res_valid, res_hit, res_miss, res_target, res_win, res_addr};
    exp = {1'b1, h, ~h, t, w, ra};
    chk(act == exp, req, 72'(act), 72'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(res_valid == 1'b0, "R11 res_valid", 72'(res_valid), 72'(0));
    for (int w = 0; w < 5; w++)
      for (int s = 0; s < 4; s++) begin
        reg_win = 3'(w); reg_sel = 2'(s); #1;
        chk(reg_rdata == 16'h0, "R11 reg zero", 72'(reg_rdata), 72'(0));
      end
    look(32'h0000_0000);
    expect_res("R11 miss after reset", 1'b0, 4'hF, 3'd0, 32'h0000_0000);

    // idle cycle gives no result (R9)
    @(negedge clk);
    chk(res_valid == 1'b0, "R9 idle", 72'(res_valid), 72'(0));

    setwin(3'd0, 4'h0, 16'h0000, 16'h07FF, 16'h0000);
    setwin(3'd1, 4'h5, 16'hE000, 16'h07FF, 16'h1000);
    setwin(3'd2, 4'h2, 16'hE800, 16'h07FF, 16'hE800);
    setwin(3'd3, 4'h7, 16'hF000, 16'h0001, 16'h1FFF);
    setwin(3'd4, 4'h3, 16'h8000, 16'h0FFF, 16'h8000);

    // readback R1
    reg_win = 3'd3; reg_sel = 2'd0; #1;
    chk(reg_rdata == 16'h0071, "R1 ctrl readback", 72'(reg_rdata), 72'(16'h0071));
    reg_sel = 2'd1; #1;
    chk(reg_rdata == 16'hF000, "R1 base readback", 72'(reg_rdata), 72'(16'hF000));
    reg_sel = 2'd2; #1;
    chk(reg_rdata == 16'h0001, "R1 size readback", 72'(reg_rdata), 72'(16'h0001));
    reg_sel = 2'd3; #1;
    chk(reg_rdata == 16'h1FFF, "R1 remap readback", 72'(reg_rdata), 72'(16'h1FFF));

    // table walk: R3 R4 R5 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      look(VEC[v][71:40]);
      expect_res("R3/R4/R5/R7/R8 table", VEC[v][39], VEC[v][38:35], VEC[v][34:32], VEC[v][31:0]);
    end

    // back-to-back lookups, valid each cycle (R9)
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 32'h0000_0001;
    @(negedge clk);
    chk(res_valid && res_addr == 32'h1, "R9 back-to-back 1", 72'(res_addr), 72'(1));
    lk_addr = 32'hE800_0002;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(res_valid && res_win == 3'd2, "R9 back-to-back 2", 72'(res_win), 72'(2));

    // disable window 1 -> miss (R2)
    wr(3'd1, 2'd0, 16'h0050);
    look(32'hE012_3456);
    expect_res("R2 disabled window", 1'b0, 4'hF, 3'd0, 32'hE012_3456);

    // same-cycle write not yet visible (R10)
    @(negedge clk);
    reg_we = 1'b1; reg_win = 3'd1; reg_sel = 2'd0; reg_wdata = 16'h0051;
    lk_valid = 1'b1; lk_addr = 32'hE000_0000;
    @(negedge clk);
    reg_we = 1'b0;
    lk_addr = 32'hE000_0000;
    expect_res("R10 old state in write cycle", 1'b0, 4'hF, 3'd0, 32'hE000_0000);
    @(negedge clk);
    lk_valid = 1'b0;
    expect_res("R10 new state next cycle", 1'b1, 4'h5, 3'd1, 32'h1000_0000);

    // overlap priority (R6): window 3 over window 0's range
    setwin(3'd3, 4'h8, 16'h0000, 16'h0001, 16'h4000);
    look(32'h0001_0010);
    expect_res("R6 lowest index wins", 1'b1, 4'h0, 3'd0, 32'h0001_0010);
    wr(3'd0, 2'd0, 16'h0000);
    look(32'h0001_0010);
    expect_res("R6 next window after disable", 1'b1, 4'h8, 3'd3, 32'h4001_0010);

    // target code pass-through (R8)
    for (int t = 0; t < 16; t += 3) begin
      wr(3'd2, 2'd0, {8'h00, 4'(t), 4'h1});
      look(32'hE900_0000);
      expect_res("R8 target code", 1'b1, 4'(t), 3'd2, 32'hE900_0000);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule